// File: doc/BRIEF.md
# Three-Level Product-Term Logic Block

This block is the combinational output logic of a field-configurable state-machine fabric. It takes up to eight signals, a mix of primary inputs and state-register bits, and computes one output bit of the state machine. The logic is a tree of product-term cells in three levels. The first level has four wide cells. Each of these cells has 8 inputs, 4 product terms and 2 outputs. The second level has two narrow cells and the third level has one. Each narrow cell has 2 inputs, 1 product term and 1 output. The cell count halves at each level.

Switching is uneven across the tree. Only the first level has full routing: every input of every first-level cell has its own selector, which can pick any block input. The second and third levels are wired in fixed positions. The one exception is a one-bit choice that decides which of a first-level cell's two outputs reaches the next level. A signal can only move forward to the next level.

The function is written through a single serial chain, one bit per clock while the shift enable is high. Stream bit k ends in configuration bit k after a full load. The selector fields come first in the stream. The output is purely combinational in the block inputs and the held configuration.

Top module: `tri_logic_block`

## Requirements
- R1: An active-low asynchronous reset clears every configuration bit. With all bits clear, `blk_out` is 0 for every input pattern.
- R2: On each rising clock edge with `cfg_en` high, the chain shifts by one place. `cfg_din` enters the highest bit, so after 414 shifts stream bit k sits in configuration bit k. One further shift moves every bit down by one place and places the new bit on top.
- R3: First-level cell c (0..3), input j (0..7), is fed by block input number s. Here s is the 3-bit field at configuration bits 3*(8c+j) to 3*(8c+j)+2, least significant bit first.
- R4: In first-level cell c, term t (0..3), the literal of cell input j has two bits, starting at bit 96+74c+2(8t+j). The lower bit adds the input in true form and the upper bit adds it in complement form. A term with no literals is 1. A term holding both forms of one input is 0.
- R5: Output o (0..1) of first-level cell c is the OR of the terms t whose mask bit 96+74c+64+4o+t is set. This result is XORed with the polarity bit 96+74c+72+o. With no mask bit set, the output equals the polarity bit.
- R6: Second-level cell k (0..1) takes input a from first-level cell 2k and input b from cell 2k+1. The bit at 392+2k (for a) or 393+2k (for b) picks that cell's output 0 when clear and its output 1 when set.
- R7: A narrow cell uses six bits, based at 396+6k for second-level cell k and at 408 for the third-level cell. The bits, in order from the base, are: a true, a complement, b true, b complement, term enable, output polarity. The output is (enable AND term) XOR polarity.
- R8: The third-level cell takes a from second-level cell 0 and b from cell 1, and drives `blk_out`. `blk_out` follows `blk_in` with no clock edge in between.
- R9: While `cfg_en` is low, `cfg_din` and clock edges leave the configuration unchanged, so the computed function stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst_n | input | 1 | Asynchronous active-low reset, clears the configuration |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration bit |
| blk_in | input | NIN (8) | Primary inputs and state bits |
| blk_out | output | 1 | Combinational state-machine output bit |

## Verification
The bench builds the block with its default parameters: 8 block inputs, first-level cells of 8 inputs, 4 terms and 2 outputs. With these values a 414-bit chain is loaded in a few hundred cycles, and each configuration is checked against all 256 input patterns. Directed configurations route single inputs, complemented inputs, empty and contradictory terms, and both output-pick settings through the fixed tree. Several pseudo-random configurations are scored against an arithmetic model built from the bit positions in the requirements. Further runs cover an extra shift, idle clocks with a toggling serial input, and a reset applied after a load.

// File: rtl/lb_pkg.sv
`timescale 1ns/1ps
package lb_pkg;

    // Configuration width of one product-term cell with ni inputs,
    // np terms and no outputs: two literal bits per input per term,
    // one OR mask bit per term per output, one polarity bit per output.
    function automatic int pt_cfg_w(input int ni, input int np, input int no);
        return np * ni * 2 + no * np + no;
    endfunction

    // Width of the per-side output pick at the second level.
    function automatic int pick_w(input int outs);
        return (outs > 1) ? $clog2(outs) : 1;
    endfunction

endpackage

// File: rtl/cfg_chain.sv
`timescale 1ns/1ps
module cfg_chain #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         shift_din,
    output logic [W-1:0] cfg_q
);

    // New bit enters at the top; the first bit of the stream walks to bit 0.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (shift_en) begin
            cfg_q <= {shift_din, cfg_q[W-1:1]};
        end
    end

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> cfg_q[W-1] == $past(shift_din)); // R2

    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> cfg_q[W-2:0] == $past(cfg_q[W-1:1])); // R2

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(cfg_q)); // R9

endmodule

// File: rtl/in_switch.sv
`timescale 1ns/1ps
module in_switch #(
    parameter int NIN  = 8,
    parameter int NSEL = 8,
    parameter int SW   = 3
) (
    input  logic [NSEL*SW-1:0] sel_cfg,
    input  logic [NIN-1:0]     src,
    output logic [NSEL-1:0]    dst
);

    localparam int EXT = 1 << SW;

    logic [EXT-1:0] src_ext;

    // Selector codes past the last real input read a constant 0.
    always_comb begin
        src_ext = '0;
        src_ext[NIN-1:0] = src;
    end

    genvar j;
    generate
        for (j = 0; j < NSEL; j++) begin : g_port
            assign dst[j] = src_ext[sel_cfg[j*SW +: SW]];
        end
    endgenerate

endmodule

// File: rtl/pt_cell.sv
`timescale 1ns/1ps
module pt_cell import lb_pkg::*; #(
    parameter int NI = 2,
    parameter int NP = 1,
    parameter int NO = 1
) (
    input  logic [pt_cfg_w(NI, NP, NO)-1:0] cfg,
    input  logic [NI-1:0]                   x,
    output logic [NO-1:0]                   y
);

    localparam int AW   = NP * NI * 2;
    localparam int OMSK = AW;
    localparam int OPOL = AW + NO * NP;

    logic [NP-1:0] term;

    // AND plane: each enabled literal can clear the term.
    always_comb begin
        for (int t = 0; t < NP; t++) begin
            term[t] = 1'b1;
            for (int j = 0; j < NI; j++) begin
                if (cfg[2*(t*NI+j)] && !x[j]) term[t] = 1'b0;
                if (cfg[2*(t*NI+j)+1] && x[j]) term[t] = 1'b0;
            end
        end
    end

    // OR plane with output polarity.
    always_comb begin
        for (int o = 0; o < NO; o++) begin
            y[o] = (|(term & cfg[OMSK + o*NP +: NP])) ^ cfg[OPOL + o];
        end
    end

    always_comb begin
        for (int o = 0; o < NO; o++) begin
            if (cfg[OMSK + o*NP +: NP] == '0) begin
                AST_EMPTY_SUM: assert (y[o] == cfg[OPOL + o]); // R5
            end
        end
    end

endmodule

// File: rtl/tri_logic_block.sv
`timescale 1ns/1ps
module tri_logic_block import lb_pkg::*; #(
    parameter int NIN      = 8,
    parameter int L1_NI    = 8,
    parameter int L1_TERMS = 4,
    parameter int L1_OUTS  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_en,
    input  logic           cfg_din,
    input  logic [NIN-1:0] blk_in,
    output logic           blk_out
);

    localparam int N1      = 4;
    localparam int N2      = N1 / 2;
    localparam int SW      = $clog2(NIN);
    localparam int PW      = pick_w(L1_OUTS);
    localparam int MUX_W   = N1 * L1_NI * SW;
    localparam int C1W     = pt_cfg_w(L1_NI, L1_TERMS, L1_OUTS);
    localparam int C2W     = pt_cfg_w(2, 1, 1);
    localparam int L1_OFF  = MUX_W;
    localparam int PK_OFF  = L1_OFF + N1 * C1W;
    localparam int L2_OFF  = PK_OFF + N2 * 2 * PW;
    localparam int L3_OFF  = L2_OFF + N2 * C2W;
    localparam int CFG_W   = L3_OFF + C2W;

    logic [CFG_W-1:0]   cfg;
    logic [L1_OUTS-1:0] l1_out [N1];
    logic [N2-1:0]      l2_out;
    logic [0:0]         l3_out;

    cfg_chain #(.W(CFG_W)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (cfg_en),
        .shift_din (cfg_din),
        .cfg_q     (cfg)
    );

    genvar c, k, s;
    generate
        // Level one: full switching in front of wide cells.
        for (c = 0; c < N1; c++) begin : g_l1
            logic [L1_NI-1:0] pick;

            in_switch #(.NIN(NIN), .NSEL(L1_NI), .SW(SW)) u_sw (
                .sel_cfg (cfg[c*L1_NI*SW +: L1_NI*SW]),
                .src     (blk_in),
                .dst     (pick)
            );

            pt_cell #(.NI(L1_NI), .NP(L1_TERMS), .NO(L1_OUTS)) u_cell (
                .cfg (cfg[L1_OFF + c*C1W +: C1W]),
                .x   (pick),
                .y   (l1_out[c])
            );
        end

        // Level two: fixed pairing, only the output pick is configurable.
        for (k = 0; k < N2; k++) begin : g_l2
            logic [1:0] ab;

            for (s = 0; s < 2; s++) begin : g_side
                assign ab[s] = l1_out[2*k+s][cfg[PK_OFF + (2*k+s)*PW +: PW]];
            end

            pt_cell #(.NI(2), .NP(1), .NO(1)) u_cell (
                .cfg (cfg[L2_OFF + k*C2W +: C2W]),
                .x   (ab),
                .y   (l2_out[k +: 1])
            );
        end
    endgenerate

    // Level three: single narrow cell fed by the two level-two outputs.
    pt_cell #(.NI(2), .NP(1), .NO(1)) u_root (
        .cfg (cfg[L3_OFF +: C2W]),
        .x   (l2_out[1:0]),
        .y   (l3_out)
    );

    assign blk_out = l3_out[0];

    always_comb begin
        if (cfg == '0) begin
            AST_CLEAR_ZERO: assert (blk_out == 1'b0); // R1
        end
    end

    AST_OUT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> (!$stable(blk_in) || $stable(blk_out))); // R8

endmodule

// File: tb/sim_tri_logic_block.sv
`timescale 1ns/1ps
module sim_tri_logic_block;

    localparam int TOT = 414;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en = 1'b0;
    logic       cfg_din = 1'b0;
    logic [7:0] blk_in = '0;
    logic       blk_out;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    bit [31:0] rng = 32'h1234_5678;

    always #5 clk = ~clk;

    tri_logic_block u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .cfg_din (cfg_din),
        .blk_in  (blk_in),
        .blk_out (blk_out)
    );

    // Field positions, taken from the requirements.
    function automatic int f_mux(int c, int j);   return 3*(8*c+j); endfunction
    function automatic int f_lit(int c, int t, int j); return 96+74*c+2*(8*t+j); endfunction
    function automatic int f_msk(int c, int o, int t); return 96+74*c+64+4*o+t; endfunction
    function automatic int f_pol(int c, int o);   return 96+74*c+72+o; endfunction
    function automatic int f_pk(int k, int sd);   return 392+2*k+sd; endfunction
    function automatic int f_nb(int k);           return (k < 2) ? 396+6*k : 408; endfunction

    function automatic bit narrow(bit [TOT-1:0] c, int b, bit a, bit bb);
        bit tm;
        tm = 1'b1;
        if (c[b]   && !a)  tm = 1'b0;
        if (c[b+1] &&  a)  tm = 1'b0;
        if (c[b+2] && !bb) tm = 1'b0;
        if (c[b+3] &&  bb) tm = 1'b0;
        return (c[b+4] & tm) ^ c[b+5];
    endfunction

    function automatic bit model(bit [TOT-1:0] c, bit [7:0] x);
        bit [1:0] o1 [4];
        bit [1:0] o2;
        for (int cl = 0; cl < 4; cl++) begin
            bit [7:0] v;
            bit [3:0] tm;
            for (int j = 0; j < 8; j++) v[j] = x[c[f_mux(cl, j) +: 3]];
            for (int t = 0; t < 4; t++) begin
                tm[t] = 1'b1;
                for (int j = 0; j < 8; j++) begin
                    if (c[f_lit(cl, t, j)]   && !v[j]) tm[t] = 1'b0;
                    if (c[f_lit(cl, t, j)+1] &&  v[j]) tm[t] = 1'b0;
                end
            end
            for (int o = 0; o < 2; o++) begin
                bit sm;
                sm = 1'b0;
                for (int t = 0; t < 4; t++) if (c[f_msk(cl, o, t)] && tm[t]) sm = 1'b1;
                o1[cl][o] = sm ^ c[f_pol(cl, o)];
            end
        end
        for (int k = 0; k < 2; k++) begin
            o2[k] = narrow(c, f_nb(k), o1[2*k][c[f_pk(k, 0)]], o1[2*k+1][c[f_pk(k, 1)]]);
        end
        return narrow(c, f_nb(2), o2[0], o2[1]);
    endfunction

    function automatic bit [31:0] step(bit [31:0] s);
        s ^= s << 13;
        s ^= s >> 17;
        s ^= s << 5;
        return s;
    endfunction

    task automatic check(string req, bit act, bit exp, int pat);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s pattern %0d: got %0b want %0b", req, pat, act, exp);
        end
    endtask

    task automatic load(bit [TOT-1:0] c);
        for (int k = 0; k < TOT; k++) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_din = c[k];
        end
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    // Exhaustive input sweep against the bench model.
    task automatic sweep(bit [TOT-1:0] c, string req);
        for (int v = 0; v < 256; v++) begin
            blk_in = 8'(v);
            #1;
            check(req, blk_out, model(c, 8'(v)), v);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        bit [TOT-1:0] c;

        repeat (3) @(negedge clk);
        // R1: cleared configuration gives 0 everywhere
        for (int v = 0; v < 256; v++) begin
            blk_in = 8'(v);
            #1;
            check("R1 reset", blk_out, 1'b0, v);
        end
        rst_n = 1'b1;

        // R3: route input s straight through to the output
        for (int s = 0; s < 8; s++) begin
            c = '0;
            c[f_mux(0, 0) +: 3] = 3'(s);
            c[f_lit(0, 0, 0)] = 1'b1;
            c[f_msk(0, 0, 0)] = 1'b1;
            c[f_nb(0)] = 1'b1; c[f_nb(0)+4] = 1'b1;
            c[f_nb(2)] = 1'b1; c[f_nb(2)+4] = 1'b1;
            load(c);
            for (int v = 0; v < 256; v++) begin
                blk_in = 8'(v);
                #1;
                check("R3 mux route", blk_out, v[s], v);
            end
        end

        // R5 R6: cell 1 output 1 with inverted polarity, picked on side b
        c = '0;
        c[f_mux(1, 0) +: 3] = 3'd2;
        c[f_lit(1, 0, 0)] = 1'b1;
        c[f_msk(1, 1, 0)] = 1'b1;
        c[f_pol(1, 1)] = 1'b1;
        c[f_pk(0, 1)] = 1'b1;
        c[f_nb(0)+2] = 1'b1; c[f_nb(0)+4] = 1'b1;
        c[f_nb(2)] = 1'b1; c[f_nb(2)+4] = 1'b1;
        load(c);
        for (int v = 0; v < 256; v++) begin
            blk_in = 8'(v);
            #1;
            check("R6 side pick polarity", blk_out, ~v[2], v);
        end

        // R4 R7: contradictory term is 0, root polarity turns it into 1
        c = '0;
        c[f_lit(0, 0, 0)] = 1'b1; c[f_lit(0, 0, 0)+1] = 1'b1;
        c[f_msk(0, 0, 0)] = 1'b1;
        c[f_nb(0)] = 1'b1; c[f_nb(0)+4] = 1'b1;
        c[f_nb(2)] = 1'b1; c[f_nb(2)+4] = 1'b1; c[f_nb(2)+5] = 1'b1;
        load(c);
        for (int v = 0; v < 256; v += 17) begin
            blk_in = 8'(v);
            #1;
            check("R4 contradiction", blk_out, 1'b1, v);
        end

        // R4 R8: empty term is 1; root takes b from level-two cell 1
        c = '0;
        c[f_msk(2, 0, 3)] = 1'b1;
        c[f_nb(1)] = 1'b1; c[f_nb(1)+4] = 1'b1;
        c[f_nb(2)+2] = 1'b1; c[f_nb(2)+4] = 1'b1;
        load(c);
        for (int v = 0; v < 256; v += 17) begin
            blk_in = 8'(v);
            #1;
            check("R4 empty term", blk_out, 1'b1, v);
        end

        // R7 R8: root computes a AND NOT b with a = in0, b = in7
        c = '0;
        c[f_lit(0, 0, 0)] = 1'b1; c[f_msk(0, 0, 0)] = 1'b1;
        c[f_mux(2, 0) +: 3] = 3'd7;
        c[f_lit(2, 0, 0)] = 1'b1; c[f_msk(2, 0, 0)] = 1'b1;
        c[f_nb(0)] = 1'b1; c[f_nb(0)+4] = 1'b1;
        c[f_nb(1)] = 1'b1; c[f_nb(1)+4] = 1'b1;
        c[f_nb(2)] = 1'b1; c[f_nb(2)+3] = 1'b1; c[f_nb(2)+4] = 1'b1;
        load(c);
        for (int v = 0; v < 256; v++) begin
            blk_in = 8'(v);
            #1;
            check("R8 root and-not", blk_out, v[0] & ~v[7], v);
        end

        // R5 R7: pseudo-random configurations against the model
        for (int r = 0; r < 5; r++) begin
            c = '0;
            for (int k = 0; k < TOT; k++) begin
                rng = step(rng);
                c[k] = rng[3];
            end
            for (int cl = 0; cl < 4; cl++)
                for (int t = 0; t < 4; t++)
                    for (int j = 0; j < 8; j++) begin
                        rng = step(rng);
                        c[f_lit(cl, t, j)]   = (rng[2:0] == 3'd0);
                        c[f_lit(cl, t, j)+1] = (rng[2:0] == 3'd1);
                    end
            load(c);
            sweep(c, "R5 random config");
        end

        // R9: idle clocks with a toggling serial bit leave the function alone
        repeat (20) begin
            @(negedge clk);
            cfg_din = ~cfg_din;
        end
        sweep(c, "R9 idle hold");

        // R2: one extra shift moves everything down one place
        @(negedge clk);
        cfg_en = 1'b1; cfg_din = 1'b1;
        @(negedge clk);
        cfg_en = 1'b0;
        c = {1'b1, c[TOT-1:1]};
        sweep(c, "R2 extra shift");

        // R1: asynchronous reset after a load
        #2;
        rst_n = 1'b0;
        #1;
        for (int v = 0; v < 256; v += 5) begin
            blk_in = 8'(v);
            #1;
            check("R1 reset after load", blk_out, 1'b0, v);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule